// File: doc/BRIEF.md
# Atomic-Write Signature Filter

This block sits beside a core's private cache and remembers which words were written inside atomic sections. It keeps the record as a 256-bit Bloom filter: every atomic store drops the store key into two hashed bit positions. When the core issues an atomic load, the filter is probed with the load key. A hit tells the cache to self-invalidate that word before reading it, because another lock holder may have written it.

The filter travels with the lock. While a lock-transfer message is being built, the current filter contents are taken from the export port. The filter then empties. When a lock arrives, the filter carried by the incoming message is OR-merged into the local one.

Each cache word has a touched bit that the block keeps so that only the first atomic load of a word in a critical section can cause an invalidation. Loads to words the cache holds in the registered (owned, up-to-date) state never invalidate. The touched bits clear when a new critical section begins.

Top module: `atomic_write_sig`

## Requirements
- R1: After reset the exported signature is all zeros and no load requests self-invalidation.
- R2: An atomic store with 16-bit key K sets signature bit h0 = K[7:0] and bit h1 = K[15:8] XOR {K[4:0],K[7:5]}, visible on the signature output from the next cycle; no other bit changes.
- R3: `ld_inval` is combinational in the load cycle and is 1 only when both hashed bits of the load key are set; a key with only one of its bits set does not invalidate.
- R4: A load with `ld_registered` high never raises `ld_inval`.
- R5: After an atomic load of a cache word, later atomic loads of the same word do not raise `ld_inval` until a new critical section begins.
- R6: `cs_begin` clears all touched bits, and it applies to a load in the same cycle, which may then invalidate.
- R7: The signature output always shows the current filter; in the cycle after `xfer_out`, the filter holds only what stores and imports in the `xfer_out` cycle put there.
- R8: With `imp_valid` high, `sig_in` is OR-merged into the filter on the next edge, keeping every bit already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Atomic store this cycle |
| st_key | input | 16 | Low bits of the store's word address |
| ld_valid | input | 1 | Atomic load this cycle |
| ld_key | input | 16 | Low bits of the load's word address |
| ld_word | input | 6 | Cache word index of the load |
| ld_registered | input | 1 | Loaded word is held in registered state |
| ld_inval | output | 1 | Self-invalidate the word before the read |
| cs_begin | input | 1 | A new critical section starts |
| xfer_out | input | 1 | Lock leaves; filter is exported then cleared |
| sig_out | output | 256 | Current signature, attached to the outgoing lock |
| imp_valid | input | 1 | Lock arrived carrying a signature |
| sig_in | input | 256 | Signature carried by the arriving lock |

## Verification
The assertions assume the core presents at most one atomic load and one atomic store per cycle. They also assume that `ld_word` names the cache slot holding `ld_key`, so repeated loads of a word reuse the same index. The stimulus keeps to this: each load sequence uses a fixed word index. Imports and exports are pulsed for single cycles, as a lock message would arrive or leave. The touched-bit assertion covers only back-to-back loads of one word with no section boundary between them, which the bench produces directly.

// File: rtl/atomic_write_sig.sv
module atomic_write_sig #(
  parameter int SIG_BITS = 256,
  parameter int WORDS    = 64,
  localparam int IDX_W   = $clog2(SIG_BITS),
  localparam int KEY_W   = 2 * IDX_W,
  localparam int WIDX_W  = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                st_valid,
  input  logic [KEY_W-1:0]    st_key,
  input  logic                ld_valid,
  input  logic [KEY_W-1:0]    ld_key,
  input  logic [WIDX_W-1:0]   ld_word,
  input  logic                ld_registered,
  output logic                ld_inval,
  input  logic                cs_begin,
  input  logic                xfer_out,
  output logic [SIG_BITS-1:0] sig_out,
  input  logic                imp_valid,
  input  logic [SIG_BITS-1:0] sig_in
);

  function automatic logic [IDX_W-1:0] hash_a(input logic [KEY_W-1:0] k);
    return k[IDX_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] hash_b(input logic [KEY_W-1:0] k);
    return k[KEY_W-1:IDX_W] ^ {k[IDX_W-4:0], k[IDX_W-1:IDX_W-3]};
  endfunction

  logic [SIG_BITS-1:0] sig_q, st_bits, sig_d;
  logic [WORDS-1:0]    touched_q;
  logic [IDX_W-1:0]    st_h0, st_h1, ld_h0, ld_h1;
  logic                seen;

  assign st_h0   = hash_a(st_key);
  assign st_h1   = hash_b(st_key);
  assign ld_h0   = hash_a(ld_key);
  assign ld_h1   = hash_b(ld_key);
  assign st_bits = st_valid ? ((SIG_BITS'(1) << st_h0) | (SIG_BITS'(1) << st_h1)) : '0;
  assign sig_d   = (xfer_out ? '0 : sig_q) | st_bits | (imp_valid ? sig_in : '0);
  assign seen    = touched_q[ld_word] && !cs_begin;

  assign ld_inval = ld_valid && !ld_registered && !seen && sig_q[ld_h0] && sig_q[ld_h1];
  assign sig_out  = sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_q     <= '0;
      touched_q <= '0;
    end else begin
      sig_q <= sig_d;
      if (cs_begin) touched_q <= '0;
      if (ld_valid) touched_q[ld_word] <= 1'b1;
    end
  end

  assert_empty_no_inval_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_out == '0) |-> !ld_inval);

  assert_store_sets_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> (sig_out[$past(st_h0)] && sig_out[$past(st_h1)]));

  assert_registered_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_registered) |-> !ld_inval);

  assert_second_load_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !cs_begin) |=>
      (!(ld_valid && !cs_begin && ld_word == $past(ld_word)) || !ld_inval));

  assert_xfer_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_out && !st_valid && !imp_valid) |=> (sig_out == '0));

  assert_keep_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_out |=> ((sig_out & $past(sig_out)) == $past(sig_out)));

  assert_import_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    imp_valid |=> ((sig_out & $past(sig_in)) == $past(sig_in)));

endmodule

// File: tb/test_atomic_write_sig.sv
`timescale 1ns/1ps
module test_atomic_write_sig;
  logic         clk = 1'b0;
  logic         rst_n, st_valid, ld_valid, ld_registered, cs_begin, xfer_out, imp_valid;
  logic [15:0]  st_key, ld_key;
  logic [5:0]   ld_word;
  logic         ld_inval;
  logic [255:0] sig_out, sig_in, model;
  int           n_chk = 0, n_fail = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  atomic_write_sig i_atomic_write_sig (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_key(st_key),
    .ld_valid(ld_valid), .ld_key(ld_key), .ld_word(ld_word),
    .ld_registered(ld_registered), .ld_inval(ld_inval), .cs_begin(cs_begin),
    .xfer_out(xfer_out), .sig_out(sig_out), .imp_valid(imp_valid), .sig_in(sig_in));

  localparam logic [15:0] KEYS [8] = '{16'h0000, 16'h5678, 16'hFFFF, 16'h0101,
                                       16'hBEEF, 16'h8001, 16'h5A5A, 16'h00FF};

  function automatic logic [7:0] kh0(input logic [15:0] k); return k[7:0]; endfunction
  function automatic logic [7:0] kh1(input logic [15:0] k);
    return k[15:8] ^ {k[4:0], k[7:5]};
  endfunction
  function automatic logic [255:0] kbits(input logic [15:0] k);
    return (256'd1 << kh0(k)) | (256'd1 << kh1(k));
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    st_valid = 0; ld_valid = 0; ld_registered = 0; cs_begin = 0;
    xfer_out = 0; imp_valid = 0; st_key = 0; ld_key = 0; ld_word = 0; sig_in = '0;
  endtask

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic store(input logic [15:0] k);
    st_valid = 1; st_key = k; cyc(); idle(); model |= kbits(k);
  endtask

  task automatic clear_all();
    xfer_out = 1; cs_begin = 1; cyc(); idle(); model = '0;
  endtask

  task automatic load(input logic [15:0] k, input logic [5:0] w, input logic reg_st,
                      input logic exp, input string req);
    ld_valid = 1; ld_key = k; ld_word = w; ld_registered = reg_st; #1;
    chk(req, {255'd0, ld_inval}, {255'd0, exp});
    cyc(); idle();
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(); model = '0; rst_n = 0;
    cyc(); cyc(); rst_n = 1;
    chk("R1 reset signature", sig_out, '0);
    load(16'h1234, 6'd0, 0, 0, "R1 reset load");

    foreach (KEYS[i]) begin
      clear_all();
      chk("R7 cleared", sig_out, '0);
      store(KEYS[i]);
      chk("R2 store bits", sig_out, model);
      load(KEYS[i], 6'(i), 1, 0, "R4 registered load");
      load(KEYS[i], 6'(i + 8), 0, 1, "R3 first load hit");
      load(KEYS[i], 6'(i + 8), 0, 0, "R5 second load");
    end

    clear_all();
    store(16'h0005);
    load(16'h2805, 6'd20, 0, model[kh0(16'h2805)] & model[kh1(16'h2805)], "R3 one bit only");
    load(16'h0006, 6'd21, 0, 0, "R3 no bits");

    load(16'h0005, 6'd22, 0, 1, "R5 first");
    load(16'h0005, 6'd22, 0, 0, "R5 repeat");
    cs_begin = 1;
    load(16'h0005, 6'd22, 0, 1, "R6 same-cycle begin");
    load(16'h0005, 6'd22, 0, 0, "R6 after begin");

    sig_in = {128'h0, 128'hF0F0_0000_0000_0000_0000_0000_0000_0001};
    imp_valid = 1; cyc(); model |= {128'h0, 128'hF0F0_0000_0000_0000_0000_0000_0000_0001};
    idle();
    chk("R8 import merge", sig_out, model);

    xfer_out = 1; st_valid = 1; st_key = 16'h0303; cyc(); idle();
    model = kbits(16'h0303);
    chk("R7 xfer with store", sig_out, model);

    rst_n = 0; cyc(); rst_n = 1;
    chk("R1 mid reset", sig_out, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule